// File: doc/BRIEF.md
# Word ALU with Carry-Preserving Condition Codes

This block is a 16-bit arithmetic unit that owns a registered four-bit condition-code register holding the flags N, Z, V and C. On every clock edge where `valid_i` is high, it takes an opcode and two operand words. It registers a result word and loads a new flag set. Each operation writes the flags by its own rule.

The operations are:
- a two-operand add;
- a carry-add, which adds only the stored C to a single operand;
- increment and decrement;
- negate;
- move.

Increment, decrement and move leave C alone. Software can therefore keep a one-bit status in C across those operations. Multi-word sums are built from the least significant word upward. The carry-add pushes a pending carry into each higher word, and the plain add then folds in that word's second addend.

The stored C feeds straight back as the carry-in of the next operation, so operations may issue on consecutive cycles. Single-operand operations use the destination operand. Move uses the source operand.

Top module: `word_alu_ccr`

## Requirements
- R1: The add opcode (code 0) registers src_i + dst_i modulo 2^16. It sets C on a carry out of bit 15. It sets V when both operands share a sign and the result's sign differs from it.
- R2: The carry-add opcode (code 1) registers dst_i plus the stored C and ignores src_i. It sets C only when dst_i is 0xFFFF and the stored C is 1. It sets V only when dst_i is 0x7FFF and the stored C is 1.
- R3: Increment (code 2) and decrement (code 3) register dst_i + 1 and dst_i - 1. V is set for increment of 0x7FFF and for decrement of 0x8000. C keeps its previous value.
- R4: Negate (code 4) registers the two's complement of dst_i. It sets C unless the result is zero, and sets V exactly when the result is 0x8000.
- R5: Move (code 5) registers src_i, clears V and keeps C.
- R6: For every defined opcode, N equals result bit 15 and Z is set when the 16-bit result is zero.
- R7: Result and flags appear one clock after an accepted operation, and valid_o is high for that one cycle. When valid_i is low, the flags and valid_o do not change in response to the other inputs.
- R8: A synchronous active-high reset clears the flags, the result and valid_o.
- R9: Reserved opcodes 6 and 7 register a result of zero and leave all four flags unchanged.
- R10: The stored C serves as the carry-in of the very next operation, including back to back. A 64-bit add built from four words with add and carry-add yields the exact sum, and its final N equals bit 63 of the sum.

flags_o is packed as {N, Z, V, C}, with C in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| result_o | output | 16 | Registered result |
| valid_o | output | 1 | Result valid, one cycle after acceptance |
| flags_o | output | 4 | Condition codes {N, Z, V, C} |

## Verification
The assertions check per-cycle invariants on every cycle:
- flags hold while idle;
- C is kept through increment, decrement and move;
- N and Z agree with the registered result;
- negate's C agrees with a non-zero result;
- carry-add produces a carry only on a zero result;
- reset clears the register.

Only the scenarios can show the arithmetic values themselves, in two places:
- the exact overflow and carry corners of each opcode;
- a carry threaded through a chain of operations, including back-to-back issue.

The 64-bit sum built from word operations is also scenario-only: its correctness emerges from ten dependent steps.

// File: rtl/walu_pkg.sv
package walu_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OPC_ADD   = 3'd0,
    OPC_CADD  = 3'd1,
    OPC_INC   = 3'd2,
    OPC_DEC   = 3'd3,
    OPC_NEG   = 3'd4,
    OPC_MOV   = 3'd5,
    OPC_RSV6  = 3'd6,
    OPC_RSV7  = 3'd7
  } opcode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] MIN_NEG = {1'b1, {(WORD_W-1){1'b0}}};

  // Wide add: carry out in the top bit.
  function automatic logic [WORD_W:0] wide_add(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input logic              cin);
    return {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, cin};
  endfunction

  // Signed overflow of a + b = s.
  function automatic logic add_ovf(input logic [WORD_W-1:0] a,
                                   input logic [WORD_W-1:0] b,
                                   input logic [WORD_W-1:0] s);
    return (a[WORD_W-1] == b[WORD_W-1]) && (s[WORD_W-1] != a[WORD_W-1]);
  endfunction

  function automatic logic keeps_carry(input opcode_e op);
    return (op == OPC_INC) || (op == OPC_DEC) || (op == OPC_MOV);
  endfunction

  function automatic logic is_defined(input opcode_e op);
    return (op != OPC_RSV6) && (op != OPC_RSV7);
  endfunction

endpackage

// File: rtl/walu_datapath.sv
module walu_datapath
  import walu_pkg::*;
(
  input  opcode_e            op,
  input  logic [WORD_W-1:0]  src,
  input  logic [WORD_W-1:0]  dst,
  input  logic               c_in,
  output logic [WORD_W-1:0]  result,
  output logic               carry_gen,
  output logic               ovf_gen,
  output logic               op_known
);

  logic [WORD_W:0]   sum_two;
  logic [WORD_W:0]   sum_cin;
  logic [WORD_W-1:0] neg_val;

  assign sum_two = wide_add(src, dst, 1'b0);
  assign sum_cin = wide_add(dst, {WORD_W{1'b0}}, c_in);
  assign neg_val = ~dst + {{(WORD_W-1){1'b0}}, 1'b1};

  always_comb begin
    result    = '0;
    carry_gen = 1'b0;
    ovf_gen   = 1'b0;
    op_known  = 1'b1;
    unique case (op)
      OPC_ADD: begin
        result    = sum_two[WORD_W-1:0];
        carry_gen = sum_two[WORD_W];
        ovf_gen   = add_ovf(src, dst, sum_two[WORD_W-1:0]);
      end
      OPC_CADD: begin
        result    = sum_cin[WORD_W-1:0];
        carry_gen = sum_cin[WORD_W];
        ovf_gen   = (dst == MAX_POS) && c_in;
      end
      OPC_INC: begin
        result  = dst + {{(WORD_W-1){1'b0}}, 1'b1};
        ovf_gen = (dst == MAX_POS);
      end
      OPC_DEC: begin
        result  = dst - {{(WORD_W-1){1'b0}}, 1'b1};
        ovf_gen = (dst == MIN_NEG);
      end
      OPC_NEG: begin
        result    = neg_val;
        carry_gen = (neg_val != '0);
        ovf_gen   = (neg_val == MIN_NEG);
      end
      OPC_MOV: begin
        result = src;
      end
      default: begin
        op_known = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/walu_flag_rules.sv
module walu_flag_rules
  import walu_pkg::*;
(
  input  opcode_e            op,
  input  logic [WORD_W-1:0]  result,
  input  logic               carry_gen,
  input  logic               ovf_gen,
  input  logic               op_known,
  input  ccr_t               cur,
  output ccr_t               nxt,
  output logic               c_kept
);

  assign c_kept = keeps_carry(op);

  always_comb begin
    if (!op_known) begin
      nxt = cur;
    end else begin
      nxt.n = result[WORD_W-1];
      nxt.z = (result == '0);
      nxt.v = ovf_gen;
      nxt.c = c_kept ? cur.c : carry_gen;
    end
  end

endmodule

// File: rtl/walu_ccr_reg.sv
module walu_ccr_reg
  import walu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  ccr_t d,
  output ccr_t q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  AST_CCR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));  // R7

endmodule

// File: rtl/word_alu_ccr.sv
module word_alu_ccr
  import walu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [WORD_W-1:0]   src_i,
  input  logic [WORD_W-1:0]   dst_i,
  output logic [WORD_W-1:0]   result_o,
  output logic                valid_o,
  output logic [3:0]          flags_o
);

  opcode_e           op;
  ccr_t              ccr_q;
  ccr_t              ccr_d;
  logic [WORD_W-1:0] alu_res;
  logic              carry_gen;
  logic              ovf_gen;
  logic              op_known;
  logic              c_kept;
  logic [WORD_W-1:0] res_q;
  logic              vld_q;

  assign op = opcode_e'(op_i);

  walu_datapath u_dp (
    .op        (op),
    .src       (src_i),
    .dst       (dst_i),
    .c_in      (ccr_q.c),
    .result    (alu_res),
    .carry_gen (carry_gen),
    .ovf_gen   (ovf_gen),
    .op_known  (op_known)
  );

  walu_flag_rules u_fr (
    .op        (op),
    .result    (alu_res),
    .carry_gen (carry_gen),
    .ovf_gen   (ovf_gen),
    .op_known  (op_known),
    .cur       (ccr_q),
    .nxt       (ccr_d),
    .c_kept    (c_kept)
  );

  walu_ccr_reg u_ccr (
    .clk  (clk),
    .rst  (rst),
    .load (valid_i),
    .d    (ccr_d),
    .q    (ccr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= alu_res;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;
  assign flags_o  = ccr_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (flags_o == 4'b0 && !valid_o && result_o == '0));  // R8

  AST_KEEP_CARRY: assert property (@(posedge clk) disable iff (rst)
    (valid_i && c_kept) |=> (flags_o[0] == $past(flags_o[0])));  // R3

  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_known) |=> (flags_o[3] == result_o[WORD_W-1] &&
                               flags_o[2] == (result_o == '0)));  // R6

  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op == OPC_NEG) |=> (flags_o[0] == (result_o != '0)));  // R4

  AST_CADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op == OPC_CADD) |=> (!flags_o[0] || result_o == '0));  // R2

  AST_MOV_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op == OPC_MOV) |=> !flags_o[1]);  // R5

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !op_known) |=> ($stable(flags_o) && result_o == '0));  // R9

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);  // R7

endmodule

// File: tb/word_alu_ccr_tb_top.sv
module word_alu_ccr_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [15:0] src_i;
  logic [15:0] dst_i;
  logic [15:0] result_o;
  logic        valid_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] res;
    logic [3:0]  flg;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  logic [3:0]  mflags;

  always #5 clk = ~clk;

  word_alu_ccr dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
    .src_i(src_i), .dst_i(dst_i), .result_o(result_o),
    .valid_o(valid_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent reference: integer arithmetic on the flag rules.
  function automatic logic [19:0] model(input int op, input int s,
                                        input int d, input logic [3:0] f);
    int r; logic n, z, v, c;
    c = f[0]; v = f[1];
    case (op)
      0: begin r = s + d; c = (r > 65535); r = r % 65536;
           v = ((s >= 32768) == (d >= 32768)) && ((r >= 32768) != (d >= 32768)); end
      1: begin r = d + int'(f[0]); c = (r > 65535); r = r % 65536;
           v = (d == 32767) && f[0]; end
      2: begin r = (d + 1) % 65536; v = (d == 32767); end
      3: begin r = (d + 65535) % 65536; v = (d == 32768); end
      4: begin r = (65536 - d) % 65536; c = (r != 0); v = (r == 32768); end
      5: begin r = s; v = 1'b0; end
      default: return {16'h0, f};
    endcase
    n = (r >= 32768); z = (r == 0);
    return {r[15:0], n, z, v, c};
  endfunction

  task automatic issue(input int op, input logic [15:0] s,
                       input logic [15:0] d, input string req);
    exp_t e; logic [19:0] m;
    @(negedge clk);
    op_i = op[2:0]; src_i = s; dst_i = d; valid_i = 1'b1;
    m = model(op, int'(s), int'(d), mflags);
    mflags = m[3:0];
    e.res = m[19:4]; e.flg = m[3:0]; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_get(input int op, input logic [15:0] s,
                         input logic [15:0] d, output logic [15:0] r);
    issue(op, s, d, "R10");
    idle();
    r = result_o;
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected valid_o: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, "result", {16'h0, result_o}, {16'h0, e.res});
        chk(e.req, "flags", {28'h0, flags_o}, {28'h0, e.flg});
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mflags = 4'h0;
    chk("R8", "flags after reset", {28'h0, flags_o}, 32'h0);
    chk("R8", "valid after reset", {31'h0, valid_o}, 32'h0);
    chk("R8", "result after reset", {16'h0, result_o}, 32'h0);
  endtask

  task automatic chain64(input logic [63:0] a, input logic [63:0] b);
    logic [15:0] w [4];
    logic [15:0] r;
    logic [63:0] sum;
    for (int k = 0; k < 4; k++) w[k] = b[16*k +: 16];
    for (int i = 0; i < 4; i++) begin
      run_get(0, a[16*i +: 16], w[i], r); w[i] = r;
      for (int j = i + 1; j < 4; j++) begin
        run_get(1, 16'h0, w[j], r); w[j] = r;
      end
    end
    sum = a + b;
    chk("R10", "64-bit sum hi", {w[3], w[2]}, sum[63:32]);
    chk("R10", "64-bit sum lo", {w[1], w[0]}, sum[31:0]);
    chk("R10", "64-bit N", {31'h0, flags_o[3]}, {31'h0, sum[63]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] held;
    rst = 1'b1; valid_i = 1'b0; op_i = 3'd0; src_i = '0; dst_i = '0;
    mflags = 4'h0;
    do_reset();

    // R1 / R6: add corners
    issue(0, 16'h0001, 16'h0002, "R1");
    issue(0, 16'hFFFF, 16'h0001, "R1");
    issue(0, 16'h7FFF, 16'h0001, "R6");
    issue(0, 16'h8000, 16'h8000, "R1");
    // R2: carry-add, src ignored
    issue(0, 16'hFFFF, 16'h0001, "R1");
    issue(1, 16'hABCD, 16'hFFFF, "R2");
    issue(1, 16'h1111, 16'h7FFF, "R2");
    issue(1, 16'h2222, 16'h1234, "R2");
    // R3: inc/dec keep C
    issue(4, 16'h0000, 16'h0001, "R4");
    issue(2, 16'h0000, 16'h7FFF, "R3");
    issue(3, 16'h0000, 16'h8000, "R3");
    issue(2, 16'h0000, 16'hFFFF, "R3");
    issue(4, 16'h0000, 16'h0000, "R4");
    issue(3, 16'h0000, 16'h0000, "R3");
    // R4 / R5
    issue(4, 16'h0000, 16'h8000, "R4");
    issue(5, 16'h0000, 16'h5555, "R5");
    issue(5, 16'h9000, 16'h0000, "R5");
    // R9: reserved codes
    issue(6, 16'h1234, 16'h5678, "R9");
    issue(7, 16'hFFFF, 16'hFFFF, "R9");
    // R10: back-to-back carry feed
    issue(0, 16'hFFFF, 16'h0001, "R10");
    issue(1, 16'h0000, 16'h0010, "R10");
    idle();
    idle();
    // R7: idle inputs have no effect
    held = flags_o;
    @(negedge clk);
    op_i = 3'd4; dst_i = 16'h0005; src_i = 16'h0007; valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7", "flags held while idle", {28'h0, flags_o}, {28'h0, held});
    chk("R7", "valid_o low while idle", {31'h0, valid_o}, 32'h0);

    chain64(64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
    chain64(64'h7FFF_8000_FFFF_1234, 64'h1234_8000_0001_FFFF);
    chain64(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);

    // R8: reset mid-run after flags set
    issue(0, 16'h8000, 16'h8000, "R8");
    idle();
    do_reset();

    idle();
    chk("R7", "scoreboard drained", sb_q.size(), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule